// File: doc/BRIEF.md
# Program/Erase Completion Poller

This block sits on the host side of a byte-wide flash memory. It decides when a self-timed program or erase operation inside the memory has finished, and whether it finished correctly. After the host has issued the two-write command sequence, it pulses `start` with the kind of operation and, for a program, the byte that was written. The poller then issues back-to-back read requests and looks at two status bits of each returned byte. Bit 6 flips on every read while the memory is busy. Bit 7 carries an inverted or zero value until the memory finishes.

Once bit 6 returns the same value on two reads in a row, the operation has settled. The poller then judges bit 7, and for a program also bit 6, against the expected values. A good result ends the run with a one-cycle `done` and `pass`. A bad result, or a run that exceeds the configured cycle limit, makes the poller write the all-ones byte to the memory twice so that the memory leaves the failed state. The run then ends with `done` and `fail`.

Top module: `fpoll_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `pass`, `fail`, `rd_req` and `wr_req` are all 0.
- R2: `start` is taken only when `busy` is 0. The values of `op_erase` and `exp_data` are latched with it. A `start` pulse while `busy` is 1 changes neither the latched operation nor the expected byte.
- R3: During polling, `rd_req` stays high, and each cycle with `rd_req` and `rd_ack` both high consumes one byte from `rd_data`. Gaps in `rd_ack` only stretch the run and do not change the verdict.
- R4: An operation counts as settled when bit 6 of a read equals bit 6 of the read just before it within the same run. The first read of a run never settles. With `rd_ack` held high, the verdict for a run that settles on read n is visible n cycles after the `start` edge.
- R5: For a program (`op_erase` = 0), a settled read passes when its bits 7 and 6 both equal bits 7 and 6 of `exp_data`. Bits 5 to 0 are ignored.
- R6: For an erase (`op_erase` = 1), a settled read passes when its bit 7 is 1.
- R7: A settled read that does not pass starts the recovery sequence. `wr_req` is raised with `wr_data` = FFH and held until `wr_ack`, and this happens twice. `done` and `fail` are raised on the edge that accepts the second write.
- R8: If no verdict has been reached, the run aborts on the edge that ends cycle `timeout_limit`+1 after the `start` edge. Recovery as in R7 follows.
- R9: `done` is high for exactly one cycle per run, and at that time exactly one of `pass` and `fail` is high. `pass` and `fail` are never high without `done`.
- R10: `rd_req` and `wr_req` are never high together, and neither is high while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin polling; the command sequence has already been written |
| op_erase | input | 1 | 1 = erase run, 0 = program run |
| exp_data | input | DATA_W | Byte written by the program operation |
| timeout_limit | input | CNT_W | Cycle limit for polling |
| rd_req | output | 1 | Read request to the memory |
| rd_ack | input | 1 | Read accepted; `rd_data` valid |
| rd_data | input | DATA_W | Byte returned by the memory |
| wr_req | output | 1 | Recovery write request |
| wr_data | output | DATA_W | Recovery write byte (all ones) |
| wr_ack | input | 1 | Recovery write accepted |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| pass | output | 1 | Run ended good (with `done`) |
| fail | output | 1 | Run ended bad or timed out (with `done`) |

## Verification
The assertions assume that `rd_ack` and `wr_ack` rise only while the matching request is high, and that `start` is a single-cycle pulse. The bench's read and write responders drive an acknowledge only on a negative edge at which they see the request high, so every acknowledge is consumed at the next rising edge. The responders also drop the acknowledge after each accepted write, which exercises the hold rule of R7. `start` is always driven for exactly one cycle, including the pulse injected mid-run to test R2.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;
   typedef enum logic [1:0] {
      PS_IDLE  = 2'd0,
      PS_POLL  = 2'd1,
      PS_CLR_A = 2'd2,
      PS_CLR_B = 2'd3
   } poll_state_t;
endpackage

// File: rtl/fpoll_verdict.sv
module fpoll_verdict #(
   parameter int DATA_W         = 8,
   parameter int TOGGLE_BIT     = 6,
   parameter int POLL_BIT       = 7,
   parameter bit PROG_BOTH_BITS = 1'b1
) (
   input  logic [DATA_W-1:0] rd_byte,
   input  logic [DATA_W-1:0] exp_byte,
   input  logic              is_erase,
   input  logic              have_prev,
   input  logic              prev_toggle,
   output logic              settled,
   output logic              good
);
   localparam logic [DATA_W-1:0] POLL_MASK   = DATA_W'(1) << POLL_BIT;
   localparam logic [DATA_W-1:0] TOGGLE_MASK = DATA_W'(1) << TOGGLE_BIT;

   logic [DATA_W-1:0] prog_mask;
   logic              cur_toggle;

   generate
      if (PROG_BOTH_BITS) begin : g_both
         assign prog_mask = POLL_MASK | TOGGLE_MASK;
      end else begin : g_poll_only
         assign prog_mask = POLL_MASK;
      end
   endgenerate

   assign cur_toggle = |(rd_byte & TOGGLE_MASK);
   assign settled    = have_prev && (cur_toggle == prev_toggle);

   always_comb begin
      if (is_erase) good = ((rd_byte & POLL_MASK) == POLL_MASK);
      else          good = (((rd_byte ^ exp_byte) & prog_mask) == '0);
   end
endmodule

// File: rtl/fpoll_watchdog.sv
module fpoll_watchdog #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [CNT_W-1:0] limit,
   output logic             expired
);
   localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   assign expired = (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (clr)             cnt_q <= '0;
      else if (en && !expired)  cnt_q <= cnt_q + STEP;
   end
endmodule

// File: rtl/fpoll_seq.sv
module fpoll_seq
   import fpoll_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int TOGGLE_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              op_erase,
   input  logic [DATA_W-1:0] exp_data,
   input  logic              rd_ack,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              wr_ack,
   input  logic              settled,
   input  logic              good,
   input  logic              expired,
   output logic              is_erase,
   output logic [DATA_W-1:0] exp_byte,
   output logic              have_prev,
   output logic              prev_toggle,
   output logic              cnt_clr,
   output logic              cnt_en,
   output logic              rd_req,
   output logic              wr_req,
   output logic              busy,
   output logic              done,
   output logic              pass,
   output logic              fail
);
   poll_state_t st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= PS_IDLE;
         is_erase    <= 1'b0;
         exp_byte    <= '0;
         have_prev   <= 1'b0;
         prev_toggle <= 1'b0;
         done        <= 1'b0;
         pass        <= 1'b0;
         fail        <= 1'b0;
      end else begin
         done <= 1'b0;
         pass <= 1'b0;
         fail <= 1'b0;
         case (st_q)
            PS_IDLE: begin
               if (start) begin
                  is_erase  <= op_erase;
                  exp_byte  <= exp_data;
                  have_prev <= 1'b0;
                  st_q      <= PS_POLL;
               end
            end
            PS_POLL: begin
               if (rd_ack && settled) begin
                  if (good) begin
                     done <= 1'b1;
                     pass <= 1'b1;
                     st_q <= PS_IDLE;
                  end else begin
                     st_q <= PS_CLR_A;
                  end
               end else if (expired) begin
                  st_q <= PS_CLR_A;
               end else if (rd_ack) begin
                  prev_toggle <= rd_data[TOGGLE_BIT];
                  have_prev   <= 1'b1;
               end
            end
            PS_CLR_A: begin
               if (wr_ack) st_q <= PS_CLR_B;
            end
            PS_CLR_B: begin
               if (wr_ack) begin
                  done <= 1'b1;
                  fail <= 1'b1;
                  st_q <= PS_IDLE;
               end
            end
            default: st_q <= PS_IDLE;
         endcase
      end
   end

   assign rd_req  = (st_q == PS_POLL);
   assign wr_req  = (st_q == PS_CLR_A) || (st_q == PS_CLR_B);
   assign busy    = (st_q != PS_IDLE);
   assign cnt_clr = (st_q == PS_IDLE);
   assign cnt_en  = (st_q == PS_POLL);
endmodule

// File: rtl/fpoll_top.sv
module fpoll_top #(
   parameter int DATA_W         = 8,
   parameter int CNT_W          = 16,
   parameter int TOGGLE_BIT     = 6,
   parameter int POLL_BIT       = 7,
   parameter bit PROG_BOTH_BITS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              op_erase,
   input  logic [DATA_W-1:0] exp_data,
   input  logic [CNT_W-1:0]  timeout_limit,
   output logic              rd_req,
   input  logic              rd_ack,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_req,
   output logic [DATA_W-1:0] wr_data,
   input  logic              wr_ack,
   output logic              busy,
   output logic              done,
   output logic              pass,
   output logic              fail
);
   generate
      if (DATA_W < 2)                     $error("DATA_W must hold both status bits");
      if (TOGGLE_BIT >= DATA_W)           $error("TOGGLE_BIT outside data width");
      if (POLL_BIT >= DATA_W)             $error("POLL_BIT outside data width");
      if (TOGGLE_BIT == POLL_BIT)         $error("status bits must differ");
      if (CNT_W < 1)                      $error("CNT_W must be positive");
   endgenerate

   logic              is_erase;
   logic [DATA_W-1:0] exp_byte;
   logic              have_prev;
   logic              prev_toggle;
   logic              settled;
   logic              good;
   logic              cnt_clr;
   logic              cnt_en;
   logic              expired;

   assign wr_data = '1;

   fpoll_seq #(.DATA_W(DATA_W), .TOGGLE_BIT(TOGGLE_BIT)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
      .exp_data(exp_data), .rd_ack(rd_ack), .rd_data(rd_data), .wr_ack(wr_ack),
      .settled(settled), .good(good), .expired(expired),
      .is_erase(is_erase), .exp_byte(exp_byte), .have_prev(have_prev),
      .prev_toggle(prev_toggle), .cnt_clr(cnt_clr), .cnt_en(cnt_en),
      .rd_req(rd_req), .wr_req(wr_req), .busy(busy),
      .done(done), .pass(pass), .fail(fail)
   );

   fpoll_verdict #(
      .DATA_W(DATA_W), .TOGGLE_BIT(TOGGLE_BIT), .POLL_BIT(POLL_BIT),
      .PROG_BOTH_BITS(PROG_BOTH_BITS)
   ) u_verdict (
      .rd_byte(rd_data), .exp_byte(exp_byte), .is_erase(is_erase),
      .have_prev(have_prev), .prev_toggle(prev_toggle),
      .settled(settled), .good(good)
   );

   fpoll_watchdog #(.CNT_W(CNT_W)) u_wd (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en),
      .limit(timeout_limit), .expired(expired)
   );
endmodule

// File: rtl/fpoll_chk.sv
module fpoll_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              rd_req,
   input logic              rd_ack,
   input logic              wr_req,
   input logic [DATA_W-1:0] wr_data,
   input logic              wr_ack,
   input logic              busy,
   input logic              done,
   input logic              pass,
   input logic              fail
);
   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!rd_req && !wr_req));                         // R10
   AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req && wr_req));                                    // R10
   AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_ack) |=> wr_req);                         // R7
   AST_WR_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> (wr_data == {DATA_W{1'b1}}));                 // R7
   AST_FAIL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |-> $past(wr_req && wr_ack));                // R7
   AST_PASS_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pass) |-> $past(rd_req && rd_ack));                // R4
   AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pass != fail));                                // R9
   AST_FLAG_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (pass || fail) |-> done);                                // R9
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                         // R9
   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);                              // R2
endmodule

bind fpoll_top fpoll_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .rd_ack(rd_ack),
   .wr_req(wr_req), .wr_data(wr_data), .wr_ack(wr_ack), .busy(busy),
   .done(done), .pass(pass), .fail(fail)
);

// File: tb/fpoll_top_bench.sv
module fpoll_top_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        op_erase = 1'b0;
   logic [7:0]  exp_data = 8'h00;
   logic [15:0] timeout_limit = 16'd1000;
   logic        rd_req;
   logic        rd_ack = 1'b0;
   logic [7:0]  rd_data = 8'h00;
   logic        wr_req;
   logic [7:0]  wr_data;
   logic        wr_ack = 1'b0;
   logic        busy, done, pass, fail;

   int n_chk = 0;
   int n_bad = 0;

   logic [7:0] script [0:63];
   int  script_len = 1;
   int  rd_idx = 0;
   bit  serve_en = 1'b1;
   bit  gap_mode = 1'b0;
   int  wr_cnt = 0;
   int  wr_ff_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpoll_top u_fpoll_top (
      .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
      .exp_data(exp_data), .timeout_limit(timeout_limit),
      .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
      .wr_req(wr_req), .wr_data(wr_data), .wr_ack(wr_ack),
      .busy(busy), .done(done), .pass(pass), .fail(fail)
   );

   // read responder
   initial begin
      forever begin
         @(negedge clk);
         if (serve_en && rd_req && !(gap_mode && rd_ack)) begin
            rd_ack  = 1'b1;
            rd_data = script[(rd_idx < script_len) ? rd_idx : script_len - 1];
            rd_idx++;
         end else begin
            rd_ack = 1'b0;
         end
      end
   end

   // write responder: acknowledge every other cycle
   initial begin
      forever begin
         @(negedge clk);
         if (wr_req && !wr_ack) begin
            wr_ack = 1'b1;
            wr_cnt++;
            if (wr_data == 8'hFF) wr_ff_cnt++;
         end else begin
            wr_ack = 1'b0;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // run one poll; inject < 0 means no second start pulse
   task automatic launch(input bit op, input logic [7:0] expb, input int lim, input int inject,
                         output int cyc, output int first_wr, output bit p, output bit f);
      rd_idx = 0; wr_cnt = 0; wr_ff_cnt = 0; first_wr = -1; p = 0; f = 0;
      @(negedge clk);
      start = 1'b1; op_erase = op; exp_data = expb; timeout_limit = 16'(lim);
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (cyc < 2000) begin
         if (wr_req && first_wr < 0) first_wr = cyc;
         if (done) begin p = pass; f = fail; break; end
         if (cyc == inject) begin start = 1'b1; op_erase = 1'b1; exp_data = 8'hFF; end
         else start = 1'b0;
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk(!busy, "R1 busy", busy, 0);
      chk(!done && !pass && !fail, "R1 flags", {done, pass, fail}, 0);
      chk(!rd_req, "R1 rd_req", rd_req, 0);
      chk(!wr_req, "R1 wr_req", wr_req, 0);
   endtask

   task automatic t_prog_pass();
      int c, fw; bit p, f;
      script[0]=8'h00; script[1]=8'h40; script[2]=8'h00; script[3]=8'hA5; script[4]=8'hA5;
      script_len = 5; gap_mode = 0; serve_en = 1;
      launch(1'b0, 8'hA5, 1000, -1, c, fw, p, f);
      chk(p && !f, "R5 program pass", p, 1);
      chk(rd_idx == 4, "R4 reads to settle", rd_idx, 4);
      chk(c == 4, "R4 verdict cycle", c, 4);
      chk(wr_cnt == 0, "R5 no recovery writes", wr_cnt, 0);
   endtask

   task automatic t_prog_dontcare();
      int c, fw; bit p, f;
      script[0]=8'h00; script[1]=8'h40; script[2]=8'h00; script[3]=8'h40; script[4]=8'hD7;
      script_len = 5; gap_mode = 0; serve_en = 1;
      launch(1'b0, 8'hC0, 1000, -1, c, fw, p, f);
      chk(p && !f, "R5 low bits ignored", p, 1);
      chk(rd_idx == 5, "R4 reads to settle", rd_idx, 5);
   endtask

   task automatic t_prog_fail();
      int c, fw; bit p, f;
      script[0]=8'h00; script[1]=8'h40; script[2]=8'h00; script[3]=8'h80; script[4]=8'h80;
      script_len = 5; gap_mode = 0; serve_en = 1;
      launch(1'b0, 8'hC3, 1000, -1, c, fw, p, f);
      chk(f && !p, "R7 bit6 mismatch fails", f, 1);
      chk(rd_idx == 4, "R7 reads before verdict", rd_idx, 4);
      chk(wr_cnt == 2, "R7 recovery write count", wr_cnt, 2);
      chk(wr_ff_cnt == 2, "R7 recovery byte FFH", wr_ff_cnt, 2);
   endtask

   task automatic t_erase_pass_gaps();
      int c, fw; bit p, f;
      script[0]=8'h00; script[1]=8'h40; script[2]=8'h00; script[3]=8'h40; script[4]=8'hC0;
      script_len = 5; gap_mode = 1; serve_en = 1;
      launch(1'b1, 8'h00, 1000, -1, c, fw, p, f);
      gap_mode = 0;
      chk(p && !f, "R6 erase pass", p, 1);
      chk(rd_idx == 5, "R3 one byte per ack", rd_idx, 5);
   endtask

   task automatic t_erase_fail();
      int c, fw; bit p, f;
      script[0]=8'h00; script[1]=8'h40; script[2]=8'h00; script[3]=8'h00;
      script_len = 4; gap_mode = 0; serve_en = 1;
      launch(1'b1, 8'hFF, 1000, -1, c, fw, p, f);
      chk(f && !p, "R6 erase bit7 low fails", f, 1);
      chk(wr_cnt == 2, "R7 erase recovery writes", wr_cnt, 2);
   endtask

   task automatic t_start_ignored();
      int c, fw; bit p, f;
      script[0]=8'h80; script[1]=8'hC0; script[2]=8'h80; script[3]=8'hC0;
      script[4]=8'h00; script[5]=8'h00;
      script_len = 6; gap_mode = 0; serve_en = 1;
      launch(1'b0, 8'h00, 1000, 2, c, fw, p, f);
      chk(p && !f, "R2 mid-run start ignored", p, 1);
      chk(rd_idx == 6, "R2 run length unchanged", rd_idx, 6);
   endtask

   task automatic t_timeout_noack();
      int c, fw; bit p, f;
      serve_en = 0; gap_mode = 0;
      launch(1'b0, 8'h55, 10, -1, c, fw, p, f);
      serve_en = 1;
      chk(f && !p, "R8 timeout fails", f, 1);
      chk(fw == 11, "R8 abort cycle", fw, 11);
      chk(wr_cnt == 2, "R8 recovery writes", wr_cnt, 2);
   endtask

   task automatic t_timeout_toggling();
      int c, fw; bit p, f;
      for (int i = 0; i < 64; i++) script[i] = (i % 2 == 1) ? 8'h40 : 8'h00;
      script_len = 64; gap_mode = 0; serve_en = 1;
      launch(1'b1, 8'h00, 20, -1, c, fw, p, f);
      chk(f && !p, "R8 endless toggle fails", f, 1);
      chk(rd_idx == 21, "R8 reads before abort", rd_idx, 21);
      chk(!rd_req && !wr_req && !busy, "R10 idle after run", busy, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      script[0] = 8'h00;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_prog_pass();
      t_prog_dontcare();
      t_prog_fail();
      t_erase_pass_gaps();
      t_erase_fail();
      t_start_ignored();
      t_timeout_noack();
      t_timeout_toggling();
      t_prog_pass();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule